// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block joins two eight-line interrupt controller lanes: a primary lane that drives the processor and a secondary lane whose pending request reaches the primary on its cascade line (line 2). Each lane keeps request, in-service and previous-input state, and it selects a winner using a rotating priority offset. The primary lane's valid winner drives the single interrupt output. An acknowledge strobe returns an 8-bit vector and updates the lane or lanes that won. A lane whose winner is missing returns line 7 as a spurious vector.

A poll read returns the winning line number of the selected lane and retires that line without a vector cycle. A poll read must be armed first, and one arming allows one read. Configuration arrives on static ports: mask, trigger mode, vector base, automatic end-of-interrupt, rotate-on-auto-EOI and nesting mode. Decoding of register-write commands is handled outside this block.

Top module: `casc_ack_seq`

## Requirements
- R1: After a synchronous reset, all request, in-service, previous-input and poll-arm state is zero and the rotation offset is 0. int_o, vec_vld_o and poll_vld_o are low, and vec_o is 0.
- R2: On an edge-mode line, a request bit is set by a low-to-high change of the input. An input that stays high does not set it again. On a level-mode line (mode bit 1), the request bit follows the input every cycle.
- R3: A lane's winner is the unmasked pending line with the smallest rank (line - offset) mod 8. The winner is valid only when its rank is below the smallest rank in service. A mask bit of 1 excludes its line.
- R4: int_o is high exactly when the primary lane has a valid winner in the current state.
- R5: When ack_i is high, vec_vld_o is high in the next cycle and vec_o holds the vector. The winner's in-service bit is set. Its request bit is cleared only on an edge-mode line.
- R6: While the secondary lane has a valid winner, the primary's line-2 request is set on the next edge. Input bit 2 of the primary request port is ignored.
- R7: If the primary winner is line 2 and the secondary has a valid winner, both lanes are acknowledged. The vector is the secondary base plus the secondary line.
- R8: If the primary winner is line 2 and the secondary has no valid winner, the vector is the secondary base plus 7. Secondary state is left unchanged.
- R9: If the primary has no valid winner at acknowledge, the vector is the primary base plus 7.
- R10: With automatic end-of-interrupt on (aeoi_i bit per lane), an acknowledged line is not left in service. With rotation also on, the offset becomes (line + 1) mod 8.
- R11: poll_arm_i[k] arms lane k (0 primary, 1 secondary). An armed poll_rd_i without ack_i returns the winning line on poll_o in the next cycle, or 7 if there is none, with poll_vld_o high. The read clears that line's request and in-service bits and disarms the lane. A read that is unarmed or coincides with ack_i is ignored.
- R12: A poll read that retires a secondary line also clears the primary's line-2 request and in-service bits.
- R13: Each vector base keeps only its upper five bits. The low three bits of a vector always come from the line number.
- R14: With sfnm_i high, the primary's line-2 in-service bit is left out of the primary's in-service rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_req_i | input | 8 | Primary request lines (bit 2 ignored) |
| s_req_i | input | 8 | Secondary request lines |
| m_mask_i | input | 8 | Primary mask, 1 = excluded |
| s_mask_i | input | 8 | Secondary mask, 1 = excluded |
| m_level_i | input | 8 | Primary trigger mode, 1 = level |
| s_level_i | input | 8 | Secondary trigger mode, 1 = level |
| m_base_i | input | 8 | Primary vector base |
| s_base_i | input | 8 | Secondary vector base |
| aeoi_i | input | 2 | Automatic end-of-interrupt per lane |
| rot_aeoi_i | input | 2 | Rotate on automatic end-of-interrupt per lane |
| sfnm_i | input | 1 | Ignore primary line-2 in-service in priority |
| ack_i | input | 1 | Acknowledge strobe |
| poll_arm_i | input | 2 | Arm a poll read per lane |
| poll_rd_i | input | 1 | Poll read strobe |
| poll_sel_i | input | 1 | Poll lane select, 1 = secondary |
| int_o | output | 1 | Interrupt to processor |
| vec_o | output | 8 | Acknowledge vector |
| vec_vld_o | output | 1 | Vector valid pulse |
| poll_o | output | 3 | Poll result line |
| poll_vld_o | output | 1 | Poll result valid pulse |

## Verification
int_o is derived combinationally from registered state. It changes in the cycle after the edge that updates the state, so a request edge appears on int_o one cycle later. A secondary request takes two cycles to appear, because the cascade adds one register stage. The vector and the poll result are registered, and each is due one cycle after the edge that samples its strobe. The bench drives its inputs before a rising edge and advances its reference model across that edge. It compares every output at the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/casc_pic_pkg.sv
package casc_pic_pkg;
    localparam int LW    = 3;
    localparam int LINES = 1 << LW;
    localparam int VW    = 8;

    typedef logic [LINES-1:0] line_vec_t;
    typedef logic [LW-1:0]    line_idx_t;
    typedef logic [LW:0]      rank_t;

    typedef struct packed {
        logic      valid;
        line_idx_t line;
    } winner_t;

    localparam line_idx_t SPUR_LINE = line_idx_t'(LINES - 1);

    // smallest rotated rank present in bits, LINES when empty
    function automatic rank_t rank_of(line_vec_t bits, line_idx_t rot);
        rank_t     r;
        line_idx_t idx;
        r = rank_t'(LINES);
        for (int p = LINES - 1; p >= 0; p--) begin
            idx = line_idx_t'(p) + rot;
            if (bits[idx]) r = rank_t'(p);
        end
        return r;
    endfunction

    function automatic winner_t pick(line_vec_t pend, line_vec_t svc, line_idx_t rot);
        winner_t w;
        rank_t   rr;
        rank_t   cr;
        rr = rank_of(pend, rot);
        cr = rank_of(svc, rot);
        w.valid = (rr < cr);
        w.line  = line_idx_t'(rr[LW-1:0]) + rot;
        return w;
    endfunction
endpackage

// File: rtl/pic_lane.sv
module pic_lane
    import casc_pic_pkg::*;
#(
    parameter line_vec_t CASC_MASK = '0
) (
    input  logic      clk,
    input  logic      rst,
    input  line_vec_t req_i,
    input  line_vec_t mask_i,
    input  line_vec_t level_i,
    input  logic      aeoi_i,
    input  logic      rot_aeoi_i,
    input  logic      sfnm_i,
    input  logic      take_i,
    input  logic      drop_i,
    input  logic      casc_set_i,
    input  logic      casc_clr_i,
    output winner_t   win_o
);
    line_vec_t irr_q, isr_q, last_q;
    line_idx_t rot_q;
    line_vec_t irr_n, isr_n;
    line_idx_t rot_n;
    line_vec_t lvl, rise, sel_bit, svc_view;

    assign lvl      = level_i & ~CASC_MASK;
    assign rise     = req_i & ~last_q & ~lvl & ~CASC_MASK;
    assign svc_view = sfnm_i ? (isr_q & ~CASC_MASK) : isr_q;
    assign win_o    = pick(irr_q & ~mask_i, svc_view, rot_q);
    assign sel_bit  = line_vec_t'(1) << win_o.line;

    always_comb begin
        irr_n = irr_q | rise | (casc_set_i ? CASC_MASK : '0);
        isr_n = isr_q;
        rot_n = rot_q;
        if (take_i) begin
            irr_n = irr_n & ~(sel_bit & ~lvl);
            isr_n = isr_n | sel_bit;
            if (aeoi_i) begin
                isr_n = isr_n & ~sel_bit;
                if (rot_aeoi_i) rot_n = win_o.line + line_idx_t'(1);
            end
        end
        if (drop_i) begin
            irr_n = irr_n & ~sel_bit;
            isr_n = isr_n & ~sel_bit;
        end
        if (casc_clr_i) begin
            irr_n = irr_n & ~CASC_MASK;
            isr_n = isr_n & ~CASC_MASK;
        end
        irr_n = (irr_n & ~lvl) | (req_i & lvl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irr_q  <= '0;
            isr_q  <= '0;
            last_q <= '0;
            rot_q  <= '0;
        end else begin
            irr_q  <= irr_n;
            isr_q  <= isr_n;
            last_q <= req_i;
            rot_q  <= rot_n;
        end
    end

    // R5: acknowledged line enters service unless auto-EOI
    a_r5_take_in_service: assert property (@(posedge clk) disable iff (rst)
        (take_i && !aeoi_i && !drop_i && !casc_clr_i) |=> isr_q[$past(win_o.line)]);

    // R10: auto-EOI leaves nothing in service for that line
    a_r10_aeoi_clears: assert property (@(posedge clk) disable iff (rst)
        (take_i && aeoi_i) |=> !isr_q[$past(win_o.line)]);

    // R10: rotation offset follows the acknowledged line
    a_r10_rotate: assert property (@(posedge clk) disable iff (rst)
        (take_i && aeoi_i && rot_aeoi_i) |=> rot_q == $past(win_o.line) + line_idx_t'(1));

    // R6: cascade request lands on the cascade line
    a_r6_casc_lands: assert property (@(posedge clk) disable iff (rst)
        (casc_set_i && !casc_clr_i && !take_i && !drop_i) |=> ((irr_q & CASC_MASK) == CASC_MASK));

    // R12: retire through the secondary clears cascade state
    a_r12_casc_clear: assert property (@(posedge clk) disable iff (rst)
        casc_clr_i |=> (((irr_q | isr_q) & CASC_MASK) == '0));

    // R2: held input never re-arms an edge line
    a_r2_no_reedge: assert property (@(posedge clk) disable iff (rst)
        (take_i && !lvl[win_o.line] && !CASC_MASK[win_o.line] && !drop_i) |=> !irr_q[$past(win_o.line)]
            || $rose(req_i[$past(win_o.line)]));
endmodule

// File: rtl/casc_ack_seq.sv
module casc_ack_seq
    import casc_pic_pkg::*;
#(
    parameter int CASC_LINE = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [LINES-1:0] m_req_i,
    input  logic [LINES-1:0] s_req_i,
    input  logic [LINES-1:0] m_mask_i,
    input  logic [LINES-1:0] s_mask_i,
    input  logic [LINES-1:0] m_level_i,
    input  logic [LINES-1:0] s_level_i,
    input  logic [VW-1:0]   m_base_i,
    input  logic [VW-1:0]   s_base_i,
    input  logic [1:0]      aeoi_i,
    input  logic [1:0]      rot_aeoi_i,
    input  logic            sfnm_i,
    input  logic            ack_i,
    input  logic [1:0]      poll_arm_i,
    input  logic            poll_rd_i,
    input  logic            poll_sel_i,
    output logic            int_o,
    output logic [VW-1:0]   vec_o,
    output logic            vec_vld_o,
    output logic [LW-1:0]   poll_o,
    output logic            poll_vld_o
);
    localparam int NLANE = 2;
    localparam line_vec_t CMASK = line_vec_t'(1) << CASC_LINE;

    line_vec_t req   [NLANE];
    line_vec_t mask  [NLANE];
    line_vec_t level [NLANE];
    winner_t   win   [NLANE];
    logic [NLANE-1:0] take, drop;
    logic [NLANE-1:0] poll_flag_q;

    assign req[0]   = m_req_i;
    assign req[1]   = s_req_i;
    assign mask[0]  = m_mask_i;
    assign mask[1]  = s_mask_i;
    assign level[0] = m_level_i;
    assign level[1] = s_level_i;

    logic m_is_casc, poll_go, poll_hit;
    logic [VW-1:0] vec_n;
    line_idx_t     poll_n;

    assign m_is_casc = (win[0].line == line_idx_t'(CASC_LINE));
    assign take[0]   = ack_i & win[0].valid;
    assign take[1]   = take[0] & m_is_casc & win[1].valid;
    assign poll_go   = poll_rd_i & ~ack_i & poll_flag_q[poll_sel_i];
    assign drop[0]   = poll_go & ~poll_sel_i & win[0].valid;
    assign drop[1]   = poll_go &  poll_sel_i & win[1].valid;
    assign poll_hit  = win[poll_sel_i].valid;
    assign poll_n    = poll_hit ? win[poll_sel_i].line : SPUR_LINE;
    assign int_o     = win[0].valid;

    generate
        for (genvar g = 0; g < NLANE; g++) begin : g_lane
            pic_lane #(
                .CASC_MASK(g == 0 ? CMASK : line_vec_t'(0))
            ) u_lane (
                .clk        (clk),
                .rst        (rst),
                .req_i      (req[g]),
                .mask_i     (mask[g]),
                .level_i    (level[g]),
                .aeoi_i     (aeoi_i[g]),
                .rot_aeoi_i (rot_aeoi_i[g]),
                .sfnm_i     (g == 0 ? sfnm_i : 1'b0),
                .take_i     (take[g]),
                .drop_i     (drop[g]),
                .casc_set_i (g == 0 ? win[1].valid : 1'b0),
                .casc_clr_i (g == 0 ? drop[1] : 1'b0),
                .win_o      (win[g])
            );
        end
    endgenerate

    always_comb begin
        if (!win[0].valid)
            vec_n = {m_base_i[VW-1:LW], SPUR_LINE};
        else if (m_is_casc)
            vec_n = {s_base_i[VW-1:LW], win[1].valid ? win[1].line : SPUR_LINE};
        else
            vec_n = {m_base_i[VW-1:LW], win[0].line};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vec_o       <= '0;
            vec_vld_o   <= 1'b0;
            poll_o      <= '0;
            poll_vld_o  <= 1'b0;
            poll_flag_q <= '0;
        end else begin
            vec_vld_o  <= ack_i;
            poll_vld_o <= poll_go;
            if (ack_i)   vec_o  <= vec_n;
            if (poll_go) poll_o <= poll_n;
            poll_flag_q <= (poll_flag_q & ~(poll_go ? (NLANE'(1) << poll_sel_i) : '0)) | poll_arm_i;
        end
    end

    // R5: vector valid exactly one cycle after the strobe
    a_r5_vec_follows_ack: assert property (@(posedge clk) disable iff (rst)
        ack_i |=> vec_vld_o);
    a_r5_no_stray_vec: assert property (@(posedge clk) disable iff (rst)
        !ack_i |=> !vec_vld_o);

    // R9: spurious acknowledge on the primary
    a_r9_spurious: assert property (@(posedge clk) disable iff (rst)
        (ack_i && !win[0].valid) |=> (vec_o == {$past(m_base_i[VW-1:LW]), SPUR_LINE}));

    // R11: a poll read consumes its arming
    a_r11_disarm: assert property (@(posedge clk) disable iff (rst)
        (poll_go && !poll_arm_i[poll_sel_i]) |=> !poll_flag_q[$past(poll_sel_i)]);

    // R11: ignored reads produce no result
    a_r11_ignored: assert property (@(posedge clk) disable iff (rst)
        (poll_rd_i && ack_i) |=> !poll_vld_o);

    // R7: secondary acknowledged only through the cascade line
    a_r7_casc_only: assert property (@(posedge clk) disable iff (rst)
        take[1] |-> (take[0] && m_is_casc));
endmodule

// File: tb/sim_casc_ack_seq.sv
module sim_casc_ack_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] m_req = '0, s_req = '0, m_mask = '0, s_mask = '0;
    logic [7:0] m_level = '0, s_level = '0;
    logic [7:0] m_base = 8'h25, s_base = 8'h70;
    logic [1:0] aeoi = '0, rot_aeoi = '0, poll_arm = '0;
    logic sfnm = 1'b0, ack = 1'b0, poll_rd = 1'b0, poll_sel = 1'b0;
    logic int_o, vec_vld, poll_vld;
    logic [7:0] vec;
    logic [2:0] poll_v;

    int n_chk = 0;
    int n_fail = 0;
    string tag = "R1";

    always #5 clk = ~clk;

    casc_ack_seq u0 (
        .clk(clk), .rst(rst), .m_req_i(m_req), .s_req_i(s_req),
        .m_mask_i(m_mask), .s_mask_i(s_mask), .m_level_i(m_level), .s_level_i(s_level),
        .m_base_i(m_base), .s_base_i(s_base), .aeoi_i(aeoi), .rot_aeoi_i(rot_aeoi),
        .sfnm_i(sfnm), .ack_i(ack), .poll_arm_i(poll_arm), .poll_rd_i(poll_rd),
        .poll_sel_i(poll_sel), .int_o(int_o), .vec_o(vec), .vec_vld_o(vec_vld),
        .poll_o(poll_v), .poll_vld_o(poll_vld)
    );

    // reference model state
    logic [7:0] q_irr [2];
    logic [7:0] q_isr [2];
    logic [7:0] q_last [2];
    int  q_rot [2];
    bit  q_flag [2];
    bit  e_vvld, e_pvld;
    int  e_vec, e_poll;

    task automatic check(input string t, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
        end
    endtask

    task automatic resolve(input int k, output bit v, output int ln);
        logic [7:0] rq, sv;
        int rr, cr;
        rq = q_irr[k] & ~(k == 0 ? m_mask : s_mask);
        sv = q_isr[k];
        if (k == 0 && sfnm) sv[2] = 1'b0;
        rr = 8; cr = 8;
        for (int p = 7; p >= 0; p--) begin
            if (rq[(p + q_rot[k]) % 8]) rr = p;
            if (sv[(p + q_rot[k]) % 8]) cr = p;
        end
        v  = rr < cr;
        ln = (rr + q_rot[k]) % 8;
    endtask

    task automatic model_step();
        bit mv, sv, tk0, tk1, pgo, dr0, dr1, tk, dr;
        int ml, sl, ln;
        logic [7:0] rq, lv;
        resolve(0, mv, ml);
        resolve(1, sv, sl);
        if (rst) begin
            for (int k = 0; k < 2; k++) begin
                q_irr[k] = '0; q_isr[k] = '0; q_last[k] = '0; q_rot[k] = 0; q_flag[k] = 0;
            end
            e_vvld = 0; e_pvld = 0; e_vec = 0; e_poll = 0;
            return;
        end
        tk0 = ack && mv;
        tk1 = tk0 && ml == 2 && sv;
        pgo = poll_rd && !ack && q_flag[poll_sel];
        dr0 = pgo && !poll_sel && mv;
        dr1 = pgo && poll_sel && sv;
        e_vvld = ack;
        if (ack) begin
            if (!mv)          e_vec = (m_base & 8'hF8) + 7;
            else if (ml == 2) e_vec = (s_base & 8'hF8) + (sv ? sl : 7);
            else              e_vec = (m_base & 8'hF8) + ml;
        end
        e_pvld = pgo;
        if (pgo) e_poll = poll_sel ? (sv ? sl : 7) : (mv ? ml : 7);
        for (int k = 0; k < 2; k++) begin
            rq = (k == 0) ? m_req : s_req;
            lv = (k == 0) ? (m_level & 8'hFB) : s_level;
            tk = (k == 0) ? tk0 : tk1;
            dr = (k == 0) ? dr0 : dr1;
            ln = (k == 0) ? ml : sl;
            for (int i = 0; i < 8; i++) begin
                if (!lv[i]) begin
                    if (k == 0 && i == 2) begin
                        if (sv) q_irr[k][i] = 1'b1;
                    end else if (rq[i] && !q_last[k][i]) q_irr[k][i] = 1'b1;
                end
            end
            if (tk) begin
                if (!lv[ln]) q_irr[k][ln] = 1'b0;
                q_isr[k][ln] = 1'b1;
                if (aeoi[k]) begin
                    q_isr[k][ln] = 1'b0;
                    if (rot_aeoi[k]) q_rot[k] = (ln + 1) % 8;
                end
            end
            if (dr) begin q_irr[k][ln] = 1'b0; q_isr[k][ln] = 1'b0; end
            if (k == 0 && dr1) begin q_irr[0][2] = 1'b0; q_isr[0][2] = 1'b0; end
            q_irr[k]  = (q_irr[k] & ~lv) | (rq & lv);
            q_last[k] = rq;
        end
        if (pgo) q_flag[poll_sel] = 0;
        for (int k = 0; k < 2; k++) if (poll_arm[k]) q_flag[k] = 1;
    endtask

    task automatic tick();
        bit ev;
        int el;
        model_step();
        @(posedge clk);
        @(negedge clk);
        resolve(0, ev, el);
        check({tag, "/R4 int"}, int_o == ev, int_o, ev);
        check({tag, "/R5 vld"}, vec_vld == e_vvld, vec_vld, e_vvld);
        if (e_vvld) check({tag, " vec"}, vec == e_vec[7:0], vec, e_vec);
        check({tag, "/R11 pvld"}, poll_vld == e_pvld, poll_vld, e_pvld);
        if (e_pvld) check({tag, " poll"}, poll_v == e_poll[2:0], poll_v, e_poll);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        m_req = '0; s_req = '0; m_mask = '0; s_mask = '0; m_level = '0; s_level = '0;
        aeoi = '0; rot_aeoi = '0; sfnm = 0; ack = 0; poll_arm = '0; poll_rd = 0; poll_sel = 0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tag = "R1";
        do_reset();
        check("R1 reset int", int_o == 0, int_o, 0);
        check("R1 reset vec", vec == 0 && !vec_vld && !poll_vld, vec, 0);

        tag = "R2";
        m_req[3] = 1; tick();
        check("R2 edge sets request", int_o == 1, int_o, 1);
        tag = "R13"; do_ack();
        check("R13 base low bits", vec == 8'h23, vec, 8'h23);
        tag = "R2"; tick();
        check("R2 held input no re-set", int_o == 0, int_o, 0);
        tag = "R3"; m_req[1] = 1; tick();
        check("R3 higher rank beats service", int_o == 1, int_o, 1);
        do_ack();
        check("R5 vector line 1", vec == 8'h21, vec, 8'h21);
        m_mask[0] = 1; m_req[0] = 1; tick();
        check("R3 masked line", int_o == 0, int_o, 0);
        m_mask[0] = 0; tick();
        check("R3 unmask", int_o == 1, int_o, 1);

        tag = "R5"; do_reset();
        aeoi[0] = 1; m_level[5] = 1; m_req[5] = 1; tick();
        do_ack();
        check("R5 level vector", vec == 8'h25, vec, 8'h25);
        check("R5 level request kept", int_o == 1, int_o, 1);
        tag = "R2"; m_req[5] = 0; tick();
        check("R2 level follows input", int_o == 0, int_o, 0);

        tag = "R6"; do_reset();
        s_req[6] = 1; tick();
        check("R6 cascade lag", int_o == 0, int_o, 0);
        tick();
        check("R6 cascade request", int_o == 1, int_o, 1);
        tag = "R7"; do_ack();
        check("R7 secondary vector", vec == 8'h76, vec, 8'h76);
        tag = "R6"; do_reset();
        m_req[2] = 1; tick(); tick();
        check("R6 primary bit 2 ignored", int_o == 0, int_o, 0);

        tag = "R9"; do_reset();
        do_ack();
        check("R9 primary spurious", vec == 8'h27, vec, 8'h27);
        tag = "R8"; sfnm = 1; s_req[4] = 1; tick(); tick();
        s_mask[4] = 1; tick();
        do_ack();
        check("R8 secondary spurious", vec == 8'h77, vec, 8'h77);
        s_mask[4] = 0; tick(); tick();
        do_ack();
        check("R8 secondary untouched", vec == 8'h74, vec, 8'h74);

        tag = "R10"; do_reset();
        aeoi[0] = 1; rot_aeoi[0] = 1; m_req[0] = 1; tick();
        do_ack();
        check("R10 first vector", vec == 8'h20, vec, 8'h20);
        m_req[0] = 0; tick();
        m_req[0] = 1; m_req[3] = 1; tick();
        do_ack();
        check("R10 rotated priority", vec == 8'h23, vec, 8'h23);
        do_ack();
        check("R10 remaining line", vec == 8'h20, vec, 8'h20);

        tag = "R11"; do_reset();
        m_req[4] = 1; tick();
        poll_rd = 1; tick(); poll_rd = 0;
        check("R11 unarmed read ignored", !poll_vld && int_o, poll_vld, 0);
        poll_arm = 2'b01; tick(); poll_arm = 0;
        poll_rd = 1; tick(); poll_rd = 0;
        check("R11 poll line", poll_vld && poll_v == 3'd4, poll_v, 4);
        check("R11 request retired", int_o == 0, int_o, 0);
        m_req[6] = 1; tick();
        check("R11 service cleared", int_o == 1, int_o, 1);
        poll_arm = 2'b01; tick(); poll_arm = 0;
        poll_rd = 1; ack = 1; tick(); poll_rd = 0; ack = 0;
        check("R11 read with ack ignored", !poll_vld && vec == 8'h26, vec, 8'h26);
        poll_rd = 1; tick(); poll_rd = 0;
        check("R11 empty poll", poll_vld && poll_v == 3'd7, poll_v, 7);

        tag = "R12"; do_reset();
        s_req[2] = 1; s_req[5] = 1; tick(); tick();
        do_ack();
        check("R12 setup vector", vec == 8'h72, vec, 8'h72);
        s_req[0] = 1; tick(); tick();
        poll_arm = 2'b10; tick(); poll_arm = 0;
        poll_sel = 1; poll_rd = 1; tick(); poll_rd = 0; poll_sel = 0;
        check("R12 secondary poll line", poll_v == 3'd0, poll_v, 0);
        m_req[3] = 1; tick();
        check("R12 primary line 2 released", int_o == 1, int_o, 1);

        tag = "R14"; do_reset();
        sfnm = 1; s_req[5] = 1; tick(); tick();
        do_ack();
        s_req[1] = 1; tick(); tick();
        check("R14 nested secondary", int_o == 1, int_o, 1);
        do_ack();
        check("R14 nested vector", vec == 8'h71, vec, 8'h71);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule